// File: doc/BRIEF.md
# I/O Page Register Bank

This block holds the byte-wide control registers of the I/O page in a small console-style system-on-chip. It covers the timer, interrupt, sound and video control registers. A CPU drives an 8-bit offset, an 8-bit write value and a write strobe. Read data is combinational from the stored state. Each implemented register reads back with its unused bits forced high. Any offset the bank does not implement reads as 0xFF.

Some writes have side effects instead of, or as well as, storage:
- A write to the divider offset asks the timer to clear its divider.
- While the sound unit reports itself off, writes to sound registers are suppressed.
- A write to the master sound register merges the new enable bit with the channel status already held.
- A write to the interrupt flag register forces the unused bits high and asks for a fresh interrupt evaluation.
- A write to the DMA offset starts a copy.

The joypad select register is decoded against a key-state input. The timer, sound, video and DMA engines lie outside the block. They appear here only as pulses and status inputs.

Offset map, in hex:
- 00 joypad select
- 01 serial data
- 02 serial control
- 04 divider
- 05 timer count
- 06 timer modulo
- 07 timer control
- 0F interrupt flag
- 10 sweep
- 11 square duty/length
- 12 square envelope
- 13 noise length
- 14 noise envelope
- 15 mixer volume
- 16 panning
- 17 master sound
- 40 LCD control
- 41 LCD status
- 42 scroll Y
- 43 scroll X
- 45 line compare
- 46 DMA
- 47 background palette
- 48 sprite palette 0
- 49 sprite palette 1
- FF interrupt enable

All pulse outputs are registered. They are high during the single cycle that follows the clock edge at which the write was taken.

Top module: `iopg_regbank`

## Requirements
- R1: A read of an implemented register returns the stored byte OR'ed with its unused-bit mask. The non-zero masks are: serial control (02) 0x7E, timer control (07) 0xF8, interrupt flag (0F) 0xE0, sweep (10) 0x80, square duty (11) 0x3F, noise length (13) 0xFF, master sound (17) 0x70, LCD status (41) 0x80. All other registers have a mask of 0x00.
- R2: A read of any offset not in the map returns 0xFF.
- R3: A write to offset 04 stores nothing, and a read of offset 04 returns the `div_value` input. The write raises `div_clear` for exactly one cycle.
- R4: While `snd_enabled` is low, a write to offset 10, 11, 12, 14, 15 or 16 stores 0x00 and raises no forward pulse.
- R5: A write to the noise length register (13) is always stored and forwarded, whatever the state of `snd_enabled`.
- R6: A write to offset 17 is always forwarded with its full value. It stores bit 7 of the write, clears bits 6:4, and keeps the previously stored bits 3:0.
- R7: A write to offset 0F stores the value with bits 7:5 set, and raises `irq_recheck` for one cycle.
- R8: A write to offset 46 stores the value and raises `dma_go` for one cycle, with `dma_src` equal to the value shifted left by 8.
- R9: A read of offset 00 returns 0xC0 | ((stored | 0x0F) ^ nib). Here nib is `key_state[7:4]` when select bits 5:4 are 2'b10, `key_state[3:0]` when they are 2'b01, and 0 otherwise.
- R10: After reset the reads are as follows:
  - master sound 0xF1
  - mixer volume 0x77
  - panning 0xF3
  - LCD control 0x91
  - background palette 0xFC
  - both sprite palettes 0xFF
  - interrupt flag 0xE1 (stored 0x01)
  - interrupt enable 0x00
- R11: The interrupt enable register (FF) reads back exactly the byte written, with no mask.
- R12: While `snd_enabled` is high, a write to a gated sound register stores the value. It also raises `snd_fwd_valid` for one cycle, with the offset and data on `snd_fwd_off` and `snd_fwd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_off | input | 8 | Register offset for read and write |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 8 | Write value |
| bus_rdata | output | 8 | Combinational read value for `bus_off` |
| snd_enabled | input | 1 | Sound unit powered status |
| key_state | input | 8 | Key bits, upper and lower groups |
| div_value | input | 8 | Current divider value from the timer |
| div_clear | output | 1 | Divider reset pulse |
| irq_recheck | output | 1 | Interrupt re-evaluation pulse |
| dma_go | output | 1 | DMA start pulse |
| dma_src | output | 16 | DMA source address |
| snd_fwd_valid | output | 1 | Sound register write forward pulse |
| snd_fwd_off | output | 8 | Forwarded offset |
| snd_fwd_data | output | 8 | Forwarded data |

## Verification
The assertions assume that the write strobe is sampled only at clock edges. They also assume that `bus_wdata` and `bus_off` hold their values through the edge at which a write is taken, so that a pulse can be related to the write one cycle before it. The stimulus changes every input on the falling edge and keeps each write strobe high for one cycle only. The checks of `snd_enabled` assume it is stable across each write, so the bench changes it only while no write is pending.

// File: rtl/iopg_pkg.sv
package iopg_pkg;

    localparam int DATA_W = 8;
    localparam int OFF_W  = 8;

    typedef enum logic [4:0] {
        RID_KEYSEL, RID_SDATA, RID_SCTRL, RID_DIV, RID_TCNT, RID_TMOD,
        RID_TCTL, RID_IFLAG, RID_SWEEP, RID_SQDUTY, RID_SQENV, RID_NZLEN,
        RID_NZENV, RID_VOL, RID_PAN, RID_MASTER, RID_LCTL, RID_LSTAT,
        RID_SCY, RID_SCX, RID_LCMP, RID_DMA, RID_BGP, RID_OBP0, RID_OBP1,
        RID_IEN, RID_NONE
    } reg_id_e;

    localparam int NUM_REGS = int'(RID_NONE);

    localparam logic [OFF_W-1:0] OFF_KEYSEL = 8'h00;
    localparam logic [OFF_W-1:0] OFF_SDATA  = 8'h01;
    localparam logic [OFF_W-1:0] OFF_SCTRL  = 8'h02;
    localparam logic [OFF_W-1:0] OFF_DIV    = 8'h04;
    localparam logic [OFF_W-1:0] OFF_TCNT   = 8'h05;
    localparam logic [OFF_W-1:0] OFF_TMOD   = 8'h06;
    localparam logic [OFF_W-1:0] OFF_TCTL   = 8'h07;
    localparam logic [OFF_W-1:0] OFF_IFLAG  = 8'h0F;
    localparam logic [OFF_W-1:0] OFF_SWEEP  = 8'h10;
    localparam logic [OFF_W-1:0] OFF_SQDUTY = 8'h11;
    localparam logic [OFF_W-1:0] OFF_SQENV  = 8'h12;
    localparam logic [OFF_W-1:0] OFF_NZLEN  = 8'h13;
    localparam logic [OFF_W-1:0] OFF_NZENV  = 8'h14;
    localparam logic [OFF_W-1:0] OFF_VOL    = 8'h15;
    localparam logic [OFF_W-1:0] OFF_PAN    = 8'h16;
    localparam logic [OFF_W-1:0] OFF_MASTER = 8'h17;
    localparam logic [OFF_W-1:0] OFF_LCTL   = 8'h40;
    localparam logic [OFF_W-1:0] OFF_LSTAT  = 8'h41;
    localparam logic [OFF_W-1:0] OFF_SCY    = 8'h42;
    localparam logic [OFF_W-1:0] OFF_SCX    = 8'h43;
    localparam logic [OFF_W-1:0] OFF_LCMP   = 8'h45;
    localparam logic [OFF_W-1:0] OFF_DMA    = 8'h46;
    localparam logic [OFF_W-1:0] OFF_BGP    = 8'h47;
    localparam logic [OFF_W-1:0] OFF_OBP0   = 8'h48;
    localparam logic [OFF_W-1:0] OFF_OBP1   = 8'h49;
    localparam logic [OFF_W-1:0] OFF_IEN    = 8'hFF;

    typedef struct packed {
        logic              store;
        logic [DATA_W-1:0] val;
        logic              fwd;
        logic              div_clr;
        logic              irq;
        logic              dma;
    } wr_plan_t;

    function automatic reg_id_e decode_off(input logic [OFF_W-1:0] off);
        case (off)
            OFF_KEYSEL: return RID_KEYSEL;
            OFF_SDATA:  return RID_SDATA;
            OFF_SCTRL:  return RID_SCTRL;
            OFF_DIV:    return RID_DIV;
            OFF_TCNT:   return RID_TCNT;
            OFF_TMOD:   return RID_TMOD;
            OFF_TCTL:   return RID_TCTL;
            OFF_IFLAG:  return RID_IFLAG;
            OFF_SWEEP:  return RID_SWEEP;
            OFF_SQDUTY: return RID_SQDUTY;
            OFF_SQENV:  return RID_SQENV;
            OFF_NZLEN:  return RID_NZLEN;
            OFF_NZENV:  return RID_NZENV;
            OFF_VOL:    return RID_VOL;
            OFF_PAN:    return RID_PAN;
            OFF_MASTER: return RID_MASTER;
            OFF_LCTL:   return RID_LCTL;
            OFF_LSTAT:  return RID_LSTAT;
            OFF_SCY:    return RID_SCY;
            OFF_SCX:    return RID_SCX;
            OFF_LCMP:   return RID_LCMP;
            OFF_DMA:    return RID_DMA;
            OFF_BGP:    return RID_BGP;
            OFF_OBP0:   return RID_OBP0;
            OFF_OBP1:   return RID_OBP1;
            OFF_IEN:    return RID_IEN;
            default:    return RID_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] unused_mask(input reg_id_e id);
        case (id)
            RID_SCTRL:  return 8'h7E;
            RID_TCTL:   return 8'hF8;
            RID_IFLAG:  return 8'hE0;
            RID_SWEEP:  return 8'h80;
            RID_SQDUTY: return 8'h3F;
            RID_NZLEN:  return 8'hFF;
            RID_MASTER: return 8'h70;
            RID_LSTAT:  return 8'h80;
            default:    return 8'h00;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reset_value(input reg_id_e id);
        case (id)
            RID_IFLAG:  return 8'h01;
            RID_SWEEP:  return 8'h80;
            RID_SQDUTY: return 8'hBF;
            RID_SQENV:  return 8'hF3;
            RID_NZLEN:  return 8'hFF;
            RID_VOL:    return 8'h77;
            RID_PAN:    return 8'hF3;
            RID_MASTER: return 8'hF1;
            RID_LCTL:   return 8'h91;
            RID_BGP:    return 8'hFC;
            RID_OBP0:   return 8'hFF;
            RID_OBP1:   return 8'hFF;
            default:    return 8'h00;
        endcase
    endfunction

    function automatic logic power_gated(input reg_id_e id);
        case (id)
            RID_SWEEP, RID_SQDUTY, RID_SQENV, RID_NZENV, RID_VOL, RID_PAN:
                return 1'b1;
            default:
                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/iopg_decode.sv
module iopg_decode
    import iopg_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    output reg_id_e          id
);
    always_comb id = decode_off(off);
endmodule

// File: rtl/iopg_wrshape.sv
module iopg_wrshape
    import iopg_pkg::*;
(
    input  logic              wr,
    input  reg_id_e           id,
    input  logic [DATA_W-1:0] wdata,
    input  logic              snd_on,
    input  logic [DATA_W-1:0] master_now,
    output wr_plan_t          plan
);
    always_comb begin
        plan         = '0;
        plan.val     = wdata;
        if (wr && id != RID_NONE) begin
            plan.store = 1'b1;
            unique case (id)
                RID_DIV: begin
                    plan.store   = 1'b0;
                    plan.div_clr = 1'b1;
                end
                RID_IFLAG: begin
                    plan.val = wdata | 8'hE0;
                    plan.irq = 1'b1;
                end
                RID_DMA:    plan.dma = 1'b1;
                RID_NZLEN:  plan.fwd = 1'b1;
                RID_MASTER: begin
                    plan.fwd = 1'b1;
                    plan.val = {wdata[7], 3'b000, master_now[3:0]};
                end
                default: begin
                    if (power_gated(id)) begin
                        if (snd_on) plan.fwd = 1'b1;
                        else        plan.val = '0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/iopg_regfile.sv
module iopg_regfile
    import iopg_pkg::*;
#(
    parameter int N = NUM_REGS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  reg_id_e                  wid,
    input  logic [DATA_W-1:0]        wval,
    output logic [N-1:0][DATA_W-1:0] regs
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= reset_value(reg_id_e'(i));
            else if (we && int'(wid) == i)
                regs[i] <= wval;
        end
    end
endmodule

// File: rtl/iopg_rdmux.sv
module iopg_rdmux
    import iopg_pkg::*;
(
    input  reg_id_e                         id,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [DATA_W-1:0]               keys,
    input  logic [DATA_W-1:0]               div_in,
    output logic [DATA_W-1:0]               rdata
);
    logic [DATA_W-1:0] sel;
    logic [3:0]        nib;

    always_comb begin
        sel = regs[RID_KEYSEL];
        case (sel[5:4])
            2'b10:   nib = keys[7:4];
            2'b01:   nib = keys[3:0];
            default: nib = 4'h0;
        endcase
        case (id)
            RID_NONE:   rdata = 8'hFF;
            RID_DIV:    rdata = div_in;
            RID_KEYSEL: rdata = 8'hC0 | ((sel | 8'h0F) ^ {4'h0, nib});
            default:    rdata = regs[id] | unused_mask(id);
        endcase
    end
endmodule

// File: rtl/iopg_regbank.sv
module iopg_regbank
    import iopg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [7:0]   bus_off,
    input  logic         bus_wr,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    input  logic         snd_enabled,
    input  logic [7:0]   key_state,
    input  logic [7:0]   div_value,
    output logic         div_clear,
    output logic         irq_recheck,
    output logic         dma_go,
    output logic [15:0]  dma_src,
    output logic         snd_fwd_valid,
    output logic [7:0]   snd_fwd_off,
    output logic [7:0]   snd_fwd_data
);
    reg_id_e                         id;
    wr_plan_t                        plan;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    iopg_decode u_dec (.off(bus_off), .id(id));

    iopg_wrshape u_wr (
        .wr(bus_wr), .id(id), .wdata(bus_wdata), .snd_on(snd_enabled),
        .master_now(regs[RID_MASTER]), .plan(plan)
    );

    iopg_regfile #(.N(NUM_REGS)) u_rf (
        .clk(clk), .rst(rst), .we(plan.store), .wid(id),
        .wval(plan.val), .regs(regs)
    );

    iopg_rdmux u_rd (
        .id(id), .regs(regs), .keys(key_state), .div_in(div_value),
        .rdata(bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_clear     <= 1'b0;
            irq_recheck   <= 1'b0;
            dma_go        <= 1'b0;
            dma_src       <= '0;
            snd_fwd_valid <= 1'b0;
            snd_fwd_off   <= '0;
            snd_fwd_data  <= '0;
        end else begin
            div_clear     <= plan.div_clr;
            irq_recheck   <= plan.irq;
            dma_go        <= plan.dma;
            snd_fwd_valid <= plan.fwd;
            if (plan.dma) dma_src <= {bus_wdata, 8'h00};
            if (plan.fwd) begin
                snd_fwd_off  <= bus_off;
                snd_fwd_data <= bus_wdata;
            end
        end
    end
endmodule

// File: rtl/iopg_checker.sv
module iopg_checker (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  bus_off,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic        snd_enabled,
    input logic        div_clear,
    input logic        irq_recheck,
    input logic        dma_go,
    input logic [15:0] dma_src,
    input logic        snd_fwd_valid,
    input logic [7:0]  snd_fwd_off
);
    p_unmapped_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_off[7] && bus_off != 8'hFF) |-> bus_rdata == 8'hFF);

    p_div_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        div_clear |-> $past(bus_wr) && $past(bus_off) == 8'h04);

    p_gate_r4: assert property (@(posedge clk) disable iff (rst)
        snd_fwd_valid |-> $past(snd_enabled) || snd_fwd_off == 8'h13
                          || snd_fwd_off == 8'h17);

    p_iflag_bits_r7: assert property (@(posedge clk) disable iff (rst)
        bus_off == 8'h0F |-> bus_rdata[7:5] == 3'b111);

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        irq_recheck |-> $past(bus_wr) && $past(bus_off) == 8'h0F);

    p_dma_src_r8: assert property (@(posedge clk) disable iff (rst)
        dma_go |-> dma_src == {$past(bus_wdata), 8'h00});

    p_master_bits_r6: assert property (@(posedge clk) disable iff (rst)
        bus_off == 8'h17 |-> bus_rdata[6:4] == 3'b111);
endmodule

bind iopg_regbank iopg_checker u_chk (
    .clk(clk), .rst(rst), .bus_off(bus_off), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .snd_enabled(snd_enabled),
    .div_clear(div_clear), .irq_recheck(irq_recheck), .dma_go(dma_go),
    .dma_src(dma_src), .snd_fwd_valid(snd_fwd_valid), .snd_fwd_off(snd_fwd_off)
);

// File: tb/iopg_regbank_bench.sv
module iopg_regbank_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_off = 8'h00;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        snd_enabled = 1'b0;
    logic [7:0]  key_state = 8'h00;
    logic [7:0]  div_value = 8'h00;
    logic        div_clear, irq_recheck, dma_go, snd_fwd_valid;
    logic [15:0] dma_src;
    logic [7:0]  snd_fwd_off, snd_fwd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    iopg_regbank u_iopg_regbank (
        .clk(clk), .rst(rst), .bus_off(bus_off), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .snd_enabled(snd_enabled),
        .key_state(key_state), .div_value(div_value), .div_clear(div_clear),
        .irq_recheck(irq_recheck), .dma_go(dma_go), .dma_src(dma_src),
        .snd_fwd_valid(snd_fwd_valid), .snd_fwd_off(snd_fwd_off),
        .snd_fwd_data(snd_fwd_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read: set offset on a falling edge, sample a little later.
    task automatic rd(input logic [7:0] off, output logic [7:0] v);
        @(negedge clk);
        bus_off = off;
        #1 v = bus_rdata;
    endtask

    // Write held through one rising edge; returns at the next falling edge,
    // where the registered pulses of that write are visible.
    task automatic wr(input logic [7:0] off, input logic [7:0] d);
        @(negedge clk);
        bus_off = off; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(8'h17, v); check("R10 master", v, 8'hF1);
        rd(8'h15, v); check("R10 volume", v, 8'h77);
        rd(8'h16, v); check("R10 pan", v, 8'hF3);
        rd(8'h40, v); check("R10 lcd", v, 8'h91);
        rd(8'h47, v); check("R10 bgp", v, 8'hFC);
        rd(8'h48, v); check("R10 obp0", v, 8'hFF);
        rd(8'h49, v); check("R10 obp1", v, 8'hFF);
        rd(8'h0F, v); check("R10 iflag", v, 8'hE1);
        rd(8'hFF, v); check("R10 ien", v, 8'h00);
        check("R10 pulses", {12'h0, div_clear, irq_recheck, dma_go, snd_fwd_valid}, 16'h0);
    endtask

    task automatic t_masks;
        logic [7:0] v;
        wr(8'h02, 8'h00); rd(8'h02, v); check("R1 sctrl", v, 8'h7E);
        wr(8'h07, 8'h05); rd(8'h07, v); check("R1 tctrl", v, 8'hFD);
        wr(8'h41, 8'h03); rd(8'h41, v); check("R1 lstat", v, 8'h83);
        wr(8'h42, 8'h5A); rd(8'h42, v); check("R1 scy", v, 8'h5A);
    endtask

    task automatic t_unmapped;
        logic [7:0] v;
        rd(8'h03, v); check("R2 03", v, 8'hFF);
        rd(8'h80, v); check("R2 80", v, 8'hFF);
        wr(8'h50, 8'h12); rd(8'h50, v); check("R2 50", v, 8'hFF);
    endtask

    task automatic t_divider;
        logic [7:0] v;
        div_value = 8'h3C;
        wr(8'h04, 8'hAA);
        check("R3 pulse", {15'h0, div_clear}, 16'h1);
        rd(8'h04, v); check("R3 read", v, 8'h3C);
        check("R3 one cycle", {15'h0, div_clear}, 16'h0);
    endtask

    task automatic t_gate;
        logic [7:0] v;
        snd_enabled = 1'b0;
        wr(8'h15, 8'h55);
        check("R4 no fwd", {15'h0, snd_fwd_valid}, 16'h0);
        rd(8'h15, v); check("R4 vol zero", v, 8'h00);
        wr(8'h12, 8'hC4); rd(8'h12, v); check("R4 env zero", v, 8'h00);
        wr(8'h10, 8'h7F); rd(8'h10, v); check("R4 sweep zero", v, 8'h80);
    endtask

    task automatic t_exempt;
        wr(8'h13, 8'h12);
        check("R5 fwd", {15'h0, snd_fwd_valid}, 16'h1);
        check("R5 data", {snd_fwd_off, snd_fwd_data}, 16'h1312);
    endtask

    task automatic t_master;
        logic [7:0] v;
        wr(8'h17, 8'h0E);
        check("R6 fwd", {snd_fwd_off, snd_fwd_data}, 16'h170E);
        rd(8'h17, v); check("R6 low kept", v, 8'h71);
        wr(8'h17, 8'h80); rd(8'h17, v); check("R6 enable", v, 8'hF1);
    endtask

    task automatic t_iflag;
        logic [7:0] v;
        wr(8'h0F, 8'h05);
        check("R7 pulse", {15'h0, irq_recheck}, 16'h1);
        rd(8'h0F, v); check("R7 value", v, 8'hE5);
        check("R7 one cycle", {15'h0, irq_recheck}, 16'h0);
    endtask

    task automatic t_dma;
        logic [7:0] v;
        wr(8'h46, 8'hC3);
        check("R8 pulse", {15'h0, dma_go}, 16'h1);
        check("R8 src", dma_src, 16'hC300);
        rd(8'h46, v); check("R8 stored", v, 8'hC3);
    endtask

    task automatic t_joypad;
        logic [7:0] v;
        key_state = 8'hA5;
        wr(8'h00, 8'h20); rd(8'h00, v); check("R9 upper", v, 8'hE5);
        wr(8'h00, 8'h10); rd(8'h00, v); check("R9 lower", v, 8'hDA);
        wr(8'h00, 8'h30); rd(8'h00, v); check("R9 both", v, 8'hFF);
        wr(8'h00, 8'h00); rd(8'h00, v); check("R9 none", v, 8'hCF);
    endtask

    task automatic t_ienable;
        logic [7:0] v;
        wr(8'hFF, 8'hE7); rd(8'hFF, v); check("R11 ien", v, 8'hE7);
        wr(8'hFF, 8'h1A); rd(8'hFF, v); check("R11 ien2", v, 8'h1A);
    endtask

    task automatic t_sound_on;
        logic [7:0] v;
        snd_enabled = 1'b1;
        wr(8'h15, 8'h35);
        check("R12 fwd", {15'h0, snd_fwd_valid}, 16'h1);
        check("R12 data", {snd_fwd_off, snd_fwd_data}, 16'h1535);
        rd(8'h15, v); check("R12 stored", v, 8'h35);
        wr(8'h11, 8'h81); rd(8'h11, v); check("R12 duty", v, 8'hBF);
        snd_enabled = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_masks();
        t_unmapped();
        t_divider();
        t_gate();
        t_exempt();
        t_master();
        t_iflag();
        t_dma();
        t_joypad();
        t_ienable();
        t_sound_on();
        finish_run();
    end
endmodule